// File: doc/BRIEF.md
# Logical Sector to Track/Sector Mapper

This block turns a 16-bit logical sector number into a physical position on a disk with 18 sectors on every track. It returns a track from 0 to 39 and a sector from 1 to 18. A strobe starts a conversion. The block first checks that the number lies in the usable range. It then takes a cheap first guess, shifting right by four as if the track held 16 sectors, and lowers that guess one step per cycle until the guess is consistent. A one-cycle done pulse marks the result.

Control is a three-state machine:

- IDLE waits for the strobe. A start with a legal number takes the transition to FIX. A start with an illegal number takes the transition to REJECT.
- FIX runs one correction per cycle while twice the working track is at least the working remainder. When that test fails, FIX returns to IDLE and publishes the result.
- REJECT raises the invalid flag with done and returns to IDLE without touching the track or sector outputs.

Top module: `lsec_mapper`

## Requirements
- R1: Numbers 1 to 720 inclusive are accepted. A start with 0 or with any value above 720 ends with done=1 and invalid=1. An accepted number ends with done=1 and invalid=0.
- R2: For an accepted number n, track equals (n-1) div 18 when done is high. Its value is therefore never above 39.
- R3: For an accepted number n, sector equals ((n-1) mod 18) + 1 when done is high. Its value is therefore always in 1..18.
- R4: done is high for exactly one cycle per accepted start. Take the clock edge that samples start as edge 0. A rejected start shows done after edge 1. An accepted start shows done after edge 1+k, where k is the number of corrections and k is at most 6.
- R5: The number 720 needs the most corrections, six (from a guess of 45 down to 39). Its done therefore appears after edge 7.
- R6: A rejected start leaves track and sector at the values of the last accepted conversion.
- R7: A start that arrives while a conversion is in progress is ignored. It produces no result of its own and does not alter the result in progress.
- R8: After reset, done, invalid, track and sector are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a conversion when the block is idle |
| lsn_i | input | 16 | Logical sector number, sampled with start_i |
| track_o | output | 6 | Physical track |
| sector_o | output | 5 | Sector within the track |
| invalid_o | output | 1 | Last conversion was rejected |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The hardest cases to reach from the ports are the longest correction chains. The worst is at 720, where the first guess overshoots by six tracks. A stray start pulse landing in the middle of such a chain is equally hard to produce. The stimulus sweeps every accepted number from 1 to 720 and measures each latency, which drives every possible correction count. It then fires a second start during the six-cycle chain of 720 and watches the following cycles for an extra result. Rejected numbers are issued right after a known accepted one, so that held track and sector values can be seen at the outputs.

// File: rtl/lsec_pkg.sv
package lsec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIX    = 2'd1,
        ST_REJECT = 2'd2
    } map_state_e;
endpackage

// File: rtl/lsec_range.sv
module lsec_range #(
    parameter int LSN_W   = 16,
    parameter int MAX_LSN = 720
) (
    input  logic [LSN_W-1:0] lsn_i,
    output logic             ok_o
);
    always_comb begin
        ok_o = (lsn_i != '0) && (lsn_i <= LSN_W'(MAX_LSN));
    end
endmodule

// File: rtl/lsec_fix_step.sv
module lsec_fix_step #(
    parameter int WT   = 7,
    parameter int WR   = 9,
    parameter int STEP = 2,
    parameter int ADD  = 16
) (
    input  logic [WT-1:0] trk_i,
    input  logic [WR-1:0] rem_i,
    output logic          need_fix_o,
    output logic [WT-1:0] trk_nx_o,
    output logic [WR-1:0] rem_nx_o,
    output logic [WR-1:0] sec_o
);
    logic [WR-1:0] scaled;

    always_comb begin
        scaled     = WR'(trk_i) * WR'(STEP);
        need_fix_o = (scaled >= rem_i);
        trk_nx_o   = trk_i - 1'b1;
        rem_nx_o   = rem_i + WR'(ADD);
        sec_o      = rem_i - scaled;
    end
endmodule

// File: rtl/lsec_mapper.sv
module lsec_mapper
    import lsec_pkg::*;
#(
    parameter int LSN_W     = 16,
    parameter int TRK_W     = 6,
    parameter int SEC_W     = 5,
    parameter int MAX_LSN   = 720,
    parameter int EST_SHIFT = 4,
    parameter int MAX_FIX   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LSN_W-1:0] lsn_i,
    output logic [TRK_W-1:0] track_o,
    output logic [SEC_W-1:0] sector_o,
    output logic             invalid_o,
    output logic             done_o
);
    localparam int GUESS_SPT = 2 ** EST_SHIFT;
    localparam int STEP      = 2;
    localparam int SPT       = GUESS_SPT + STEP;
    localparam int MAX_TRK   = (MAX_LSN - 1) / SPT;
    localparam int WT        = TRK_W + 1;
    localparam int WR        = TRK_W + 3;

    map_state_e    state_q, state_d;
    logic          lsn_ok;
    logic          need_fix;
    logic [WT-1:0] trk_w, trk_nx;
    logic [WR-1:0] rem_w, rem_nx, sec_w;
    logic [LSN_W-1:0] lsn_q;

    lsec_range #(.LSN_W(LSN_W), .MAX_LSN(MAX_LSN)) u_range (
        .lsn_i (lsn_i),
        .ok_o  (lsn_ok)
    );

    lsec_fix_step #(.WT(WT), .WR(WR), .STEP(STEP), .ADD(GUESS_SPT)) u_step (
        .trk_i      (trk_w),
        .rem_i      (rem_w),
        .need_fix_o (need_fix),
        .trk_nx_o   (trk_nx),
        .rem_nx_o   (rem_nx),
        .sec_o      (sec_w)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = lsn_ok ? ST_FIX : ST_REJECT;
            ST_FIX:    if (!need_fix) state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // working registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_w     <= '0;
            rem_w     <= '0;
            lsn_q     <= '0;
            track_o   <= '0;
            sector_o  <= '0;
            invalid_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i && lsn_ok) begin
                        trk_w <= WT'(lsn_i >> EST_SHIFT);
                        rem_w <= WR'(lsn_i[EST_SHIFT-1:0]);
                        lsn_q <= lsn_i;
                    end
                end
                ST_FIX: begin
                    if (need_fix) begin
                        trk_w <= trk_nx;
                        rem_w <= rem_nx;
                    end else begin
                        track_o   <= TRK_W'(trk_w);
                        sector_o  <= SEC_W'(sec_w);
                        invalid_o <= 1'b0;
                        done_o    <= 1'b1;
                    end
                end
                ST_REJECT: begin
                    invalid_o <= 1'b1;
                    done_o    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // correction counter, observed by the bound check only
    logic [3:0] fix_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           fix_cnt <= '0;
        else if (state_q == ST_IDLE)          fix_cnt <= '0;
        else if (state_q == ST_FIX && need_fix) fix_cnt <= fix_cnt + 1'b1;
    end

    p_fix_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fix_cnt) <= MAX_FIX);

    p_track_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !invalid_o) |-> (int'(track_o) <= MAX_TRK));

    p_sector_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !invalid_o) |-> (sector_o >= SEC_W'(1) && int'(sector_o) <= SPT));

    p_identity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !invalid_o) |-> (int'(track_o) * SPT + int'(sector_o) == int'(lsn_q)));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_hold_on_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && invalid_o) |-> ($stable(track_o) && $stable(sector_o)));
endmodule

// File: tb/test_lsec_mapper.sv
module test_lsec_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] lsn = '0;
    logic [5:0]  track;
    logic [4:0]  sector;
    logic        invalid;
    logic        done;

    always #5 clk = ~clk;

    lsec_mapper i_lsec_mapper (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .lsn_i     (lsn),
        .track_o   (track),
        .sector_o  (sector),
        .invalid_o (invalid),
        .done_o    (done)
    );

    typedef struct {
        int n;
        int trk;
        int sec;
        bit inv;
        int t0;
    } exp_t;

    exp_t sb[$];
    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int pending = 0;
    int last_trk = 0;
    int last_sec = 0;
    bit prev_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, int n, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s n=%0d actual %0d expected %0d", req, n, act, exp);
        end
    endtask

    function automatic exp_t make_exp(int n);
        exp_t e;
        e.n = n;
        e.t0 = cyc;
        if (n >= 1 && n <= 720) begin
            e.inv = 1'b0;
            e.trk = (n - 1) / 18;
            e.sec = (n - 1) % 18 + 1;
            last_trk = e.trk;
            last_sec = e.sec;
        end else begin
            e.inv = 1'b1;
            e.trk = last_trk;
            e.sec = last_sec;
        end
        return e;
    endfunction

    task automatic issue(int n);
        @(negedge clk);
        sb.push_back(make_exp(n));
        pending++;
        lsn = 16'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (pending == 0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (done && prev_done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R4 done wider than one cycle actual 1 expected 0");
        end
        if (done) begin
            if (sb.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R7 unexpected result actual done=1 expected done=0");
            end else begin
                exp_t e;
                int lat;
                e = sb.pop_front();
                lat = cyc - e.t0 - 1;
                check("R1 invalid flag", e.n, int'(invalid), int'(e.inv));
                if (e.inv) begin
                    check("R6 held track", e.n, int'(track), e.trk);
                    check("R6 held sector", e.n, int'(sector), e.sec);
                    check("R4 reject latency", e.n, lat, 1);
                end else begin
                    check("R2 track", e.n, int'(track), e.trk);
                    check("R3 sector", e.n, int'(sector), e.sec);
                    check("R4 latency within 7", e.n, int'(lat >= 1 && lat <= 7), 1);
                    if (e.n == 720) check("R5 worst-case latency", e.n, lat, 7);
                end
                pending--;
            end
        end
        prev_done = done;
    end

    task automatic run_all();
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 done at reset", 0, int'(done), 0);
        check("R8 invalid at reset", 0, int'(invalid), 0);
        check("R8 track at reset", 0, int'(track), 0);
        check("R8 sector at reset", 0, int'(sector), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R3 full sweep
        for (int n = 1; n <= 720; n++) issue(n);
        // R1 R6 rejects after a known result
        issue(37);
        issue(0);
        issue(721);
        issue(500);
        issue(65535);
        issue(1024);
        issue(18);
        // R7 start during a long conversion
        @(negedge clk);
        sb.push_back(make_exp(720));
        pending++;
        lsn = 16'd720;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        lsn = 16'd100;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lsn = 16'd0;
        wait (pending == 0);
        repeat (12) @(negedge clk);
        issue(19);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule